// File: doc/BRIEF.md
# Indirect Scratch Register Window

This block gives a processor core indirect access to a set of 64-bit scratch entries through two registers. Software first loads a select register with a window code. It then reads or writes a data register, and that access is steered to the scratch entry named by the select code, or to a read-only thread-state word. Select writes that carry bits outside the permitted set are rejected, and the previous select value stays in place.

Two scratch banks exist, one for each core of a core pair. An access carries a parity bit that names the accessing core. The parity bit picks that core's own select register, and normally also its own bank. When the paired-core mode input is high, both cores are steered to the bank of the even core (the core id with bit 0 cleared). The thread-state word reports that mode in its least-significant bit. A data access to a window code that is not decoded produces a one-cycle flag.

Top module: `scratch_window`

## Requirements
- R1: After reset, both select registers read as zero, every scratch entry holds zero, and `unimp_flag` is low.
- R2: A select write whose data has no bit set outside mask 0x3F8 is stored in the select register of the accessing core. The new value appears on `sel_rdata` after the clock edge.
- R3: A select write whose data has any bit set outside mask 0x3F8 is dropped, and the select register keeps its previous value.
- R4: When (select AND 0x3E0) is zero, the data register maps to the scratch entry indexed by select bits [5:3]. A data write stores into that entry on the clock edge, and `data_rdata` shows the entry combinationally.
- R5: When (select AND 0x3E0) equals 0x1E0, `data_rdata` returns 1 if `pair_mode` is high and 0 otherwise.
- R6: With any other nonzero value of (select AND 0x3E0), `data_rdata` is zero. A data write with any nonzero value of (select AND 0x3E0), including 0x1E0, leaves every scratch entry unchanged.
- R7: With `pair_mode` low, `acc_odd`=0 uses bank 0 and `acc_odd`=1 uses bank 1. With `pair_mode` high, both parities use bank 0.
- R8: Each core parity has its own select register, chosen by `acc_odd` whatever the value of `pair_mode`.
- R9: `unimp_flag` is high for exactly the one cycle after a data read whose (select AND 0x3E0) is neither 0 nor 0x1E0, or after a data write whose (select AND 0x3E0) is nonzero. It is low after any other cycle.
- R10: A data access in the same cycle as a select write uses the select value held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pair_mode | input | 1 | High: both cores of the pair share bank 0 |
| acc_odd | input | 1 | Bit 0 of the accessing core's id |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | DATA_W | Select register write data |
| sel_rdata | output | DATA_W | Select register of the accessing core |
| data_we | input | 1 | Data register write strobe |
| data_re | input | 1 | Data register read strobe (used only for the unimplemented flag) |
| data_wdata | input | DATA_W | Data register write data |
| data_rdata | output | DATA_W | Data register read value |
| unimp_flag | output | 1 | One-cycle pulse after an access to an undecoded window |

## Verification
A select write and a data write can share one cycle for the same core. The bench provokes this by raising both strobes together after a known entry has been selected. It then judges the outcome by reading back: the data must land in the entry named by the old select value, the newly selected entry must keep its earlier contents, and the select register must hold the new code. A second pair of events that can meet is a write to an undecoded window and the flag pulse from the access before it. Back-to-back undecoded accesses must keep the flag high, and the first idle cycle after them must clear it.

// File: rtl/sxw_pkg.sv
package sxw_pkg;

    localparam int unsigned SEL_W = 10;

    localparam logic [SEL_W-1:0] SEL_OK_MASK  = 10'h3F8;
    localparam logic [SEL_W-1:0] FIELD_MASK   = 10'h3E0;
    localparam logic [SEL_W-1:0] STATUS_FIELD = 10'h1E0;

    typedef enum logic [1:0] {
        WIN_SCRATCH = 2'd0,
        WIN_STATUS  = 2'd1,
        WIN_NONE    = 2'd2
    } win_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } sel_state_t;

    typedef struct packed {
        logic unimp;
    } top_state_t;

endpackage

// File: rtl/sxw_sel_reg.sv
module sxw_sel_reg
    import sxw_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [DATA_W-1:0]    wdata,
    output logic [SEL_W-1:0]     sel_q
);

    sel_state_t st_d, st_q;
    logic       legal;

    always_comb begin
        legal = (~|wdata[DATA_W-1:SEL_W]) && (~|(wdata[SEL_W-1:0] & ~SEL_OK_MASK));
        st_d  = st_q;
        if (we && legal) begin
            st_d.sel = wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q = st_q.sel;

    // R3
    drop_bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !legal) |=> $stable(sel_q));

    // R2
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_q & ~SEL_OK_MASK) == '0));

endmodule

// File: rtl/sxw_decode.sv
module sxw_decode
    import sxw_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [SEL_W-1:3]  sel_hi,
    output win_e              win,
    output logic [IDX_W-1:0]  idx
);

    logic [SEL_W-1:0] field;

    always_comb begin
        field = {sel_hi, 3'b000} & FIELD_MASK;
        idx   = sel_hi[3 +: IDX_W];
        if (field == '0)               win = WIN_SCRATCH;
        else if (field == STATUS_FIELD) win = WIN_STATUS;
        else                           win = WIN_NONE;
    end

endmodule

// File: rtl/sxw_bank.sv
module sxw_bank #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata
);

    logic [ENTRIES-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[idx];

    // R6
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));

endmodule

// File: rtl/scratch_window.sv
module scratch_window
    import sxw_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned NCORES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_mode,
    input  logic               acc_odd,
    input  logic               sel_we,
    input  logic [DATA_W-1:0]  sel_wdata,
    output logic [DATA_W-1:0]  sel_rdata,
    input  logic               data_we,
    input  logic               data_re,
    input  logic [DATA_W-1:0]  data_wdata,
    output logic [DATA_W-1:0]  data_rdata,
    output logic               unimp_flag
);

    localparam int unsigned IDX_W = $clog2(ENTRIES);

    logic [NCORES-1:0][SEL_W-1:0]  sel_all;
    logic [NCORES-1:0][DATA_W-1:0] bank_rd;
    logic [NCORES-1:0]             bank_we;
    logic [SEL_W-1:0]              sel_cur;
    logic                          bank_sel;
    win_e                          win;
    logic [IDX_W-1:0]              idx;
    top_state_t                    st_d, st_q;

    for (genvar c = 0; c < NCORES; c++) begin : g_core
        sxw_sel_reg #(.DATA_W(DATA_W)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (sel_we && (acc_odd == c[0])),
            .wdata (sel_wdata),
            .sel_q (sel_all[c])
        );

        sxw_bank #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[c]),
            .idx   (idx),
            .wdata (data_wdata),
            .rdata (bank_rd[c])
        );
    end

    assign sel_cur  = sel_all[acc_odd];
    assign bank_sel = acc_odd & ~pair_mode;

    sxw_decode #(.ENTRIES(ENTRIES)) u_dec (
        .sel_hi (sel_cur[SEL_W-1:3]),
        .win    (win),
        .idx    (idx)
    );

    always_comb begin
        for (int b = 0; b < NCORES; b++) begin
            bank_we[b] = data_we && (win == WIN_SCRATCH) && (bank_sel == b[0]);
        end

        unique case (win)
            WIN_SCRATCH: data_rdata = bank_rd[bank_sel];
            WIN_STATUS:  data_rdata = {{(DATA_W-1){1'b0}}, pair_mode};
            default:     data_rdata = '0;
        endcase

        st_d.unimp = (data_re && (win == WIN_NONE)) ||
                     (data_we && (win != WIN_SCRATCH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_rdata  = {{(DATA_W-SEL_W){1'b0}}, sel_cur};
    assign unimp_flag = st_q.unimp;

    // R9
    unimp_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_re && (win == WIN_NONE)) |=> unimp_flag);

    // R9
    unimp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_re || data_we) |=> !unimp_flag);

    // R7
    pair_bank0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_mode |-> !bank_we[1]);

    // R6
    no_write_off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win != WIN_SCRATCH) |-> (bank_we == '0));

    // R7
    one_bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

endmodule

// File: tb/sim_scratch_window.sv
module sim_scratch_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pair_mode = 1'b0;
    logic        acc_odd = 1'b0;
    logic        sel_we = 1'b0;
    logic [63:0] sel_wdata = '0;
    logic [63:0] sel_rdata;
    logic        data_we = 1'b0;
    logic        data_re = 1'b0;
    logic [63:0] data_wdata = '0;
    logic [63:0] data_rdata;
    logic        unimp_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scratch_window u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_mode  (pair_mode),
        .acc_odd    (acc_odd),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .sel_rdata  (sel_rdata),
        .data_we    (data_we),
        .data_re    (data_re),
        .data_wdata (data_wdata),
        .data_rdata (data_rdata),
        .unimp_flag (unimp_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        sel_we  = 1'b0;
        data_we = 1'b0;
        data_re = 1'b0;
    endtask

    task automatic set_sel(input logic odd, input logic [63:0] v);
        acc_odd   = odd;
        sel_we    = 1'b1;
        sel_wdata = v;
        tick();
    endtask

    task automatic wr_data(input logic [63:0] v);
        data_we    = 1'b1;
        data_wdata = v;
        tick();
    endtask

    task automatic rd_pulse();
        data_re = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        acc_odd = 1'b0; #1;
        chk("R1 sel even", sel_rdata, 64'h0);
        chk("R1 data", data_rdata, 64'h0);
        chk("R1 unimp", {63'h0, unimp_flag}, 64'h0);
        acc_odd = 1'b1; #1;
        chk("R1 sel odd", sel_rdata, 64'h0);
        acc_odd = 1'b0;
    endtask

    task automatic t_sel_write();
        set_sel(1'b0, 64'h3F8);
        chk("R2 legal sel", sel_rdata, 64'h3F8);
        set_sel(1'b0, 64'h400);
        chk("R3 bit10 dropped", sel_rdata, 64'h3F8);
        set_sel(1'b0, 64'h001);
        chk("R3 bit0 dropped", sel_rdata, 64'h3F8);
        set_sel(1'b0, 64'h8000_0000_0000_0010);
        chk("R3 bit63 dropped", sel_rdata, 64'h3F8);
        acc_odd = 1'b1; #1;
        chk("R8 odd sel separate", sel_rdata, 64'h0);
        set_sel(1'b0, 64'h010);
        chk("R2 sel 0x010", sel_rdata, 64'h010);
    endtask

    task automatic t_scratch();
        acc_odd = 1'b0;
        wr_data(64'hAAAA_0000_0000_0002);
        chk("R4 entry2 write", data_rdata, 64'hAAAA_0000_0000_0002);
        set_sel(1'b0, 64'h018);
        chk("R4 entry3 empty", data_rdata, 64'h0);
        wr_data(64'hBBBB_0000_0000_0003);
        chk("R4 entry3 write", data_rdata, 64'hBBBB_0000_0000_0003);
        set_sel(1'b0, 64'h010);
        chk("R4 entry2 kept", data_rdata, 64'hAAAA_0000_0000_0002);
        set_sel(1'b1, 64'h010);
        chk("R7 bank1 empty", data_rdata, 64'h0);
        wr_data(64'hCCCC_0000_0000_1002);
        chk("R7 bank1 write", data_rdata, 64'hCCCC_0000_0000_1002);
        acc_odd = 1'b0; #1;
        chk("R7 bank0 intact", data_rdata, 64'hAAAA_0000_0000_0002);
    endtask

    task automatic t_status();
        set_sel(1'b0, 64'h1E0);
        pair_mode = 1'b0; #1;
        chk("R5 status unpaired", data_rdata, 64'h0);
        pair_mode = 1'b1; #1;
        chk("R5 status paired", data_rdata, 64'h1);
        rd_pulse();
        chk("R9 status read no flag", {63'h0, unimp_flag}, 64'h0);
        wr_data(64'h5);
        chk("R9 status write flags", {63'h0, unimp_flag}, 64'h1);
        tick();
        chk("R9 flag clears", {63'h0, unimp_flag}, 64'h0);
        pair_mode = 1'b0;
    endtask

    task automatic t_other();
        set_sel(1'b0, 64'h3F8);
        chk("R6 other read zero", data_rdata, 64'h0);
        rd_pulse();
        chk("R9 other read flags", {63'h0, unimp_flag}, 64'h1);
        wr_data(64'hDEAD);
        chk("R9 back-to-back flag", {63'h0, unimp_flag}, 64'h1);
        set_sel(1'b0, 64'h028);
        chk("R6 field 0x020 read zero", data_rdata, 64'h0);
        wr_data(64'hBEEF);
        chk("R9 field 0x020 write flags", {63'h0, unimp_flag}, 64'h1);
        set_sel(1'b0, 64'h010);
        chk("R6 entry2 untouched", data_rdata, 64'hAAAA_0000_0000_0002);
        set_sel(1'b0, 64'h018);
        chk("R6 entry3 untouched", data_rdata, 64'hBBBB_0000_0000_0003);
        set_sel(1'b0, 64'h000);
        chk("R6 entry0 untouched", data_rdata, 64'h0);
        set_sel(1'b0, 64'h008);
        chk("R6 entry1 untouched", data_rdata, 64'h0);
        rd_pulse();
        chk("R9 scratch read no flag", {63'h0, unimp_flag}, 64'h0);
    endtask

    task automatic t_pair();
        pair_mode = 1'b1;
        acc_odd   = 1'b1; #1;
        chk("R8 odd sel kept in pair mode", sel_rdata, 64'h010);
        chk("R7 odd sees bank0", data_rdata, 64'hAAAA_0000_0000_0002);
        wr_data(64'hDDDD_0000_0000_0002);
        chk("R7 paired write", data_rdata, 64'hDDDD_0000_0000_0002);
        pair_mode = 1'b0; #1;
        chk("R7 bank1 untouched", data_rdata, 64'hCCCC_0000_0000_1002);
        acc_odd = 1'b0; #1;
        chk("R8 even sel kept", sel_rdata, 64'h008);
        set_sel(1'b0, 64'h010);
        chk("R7 even sees paired write", data_rdata, 64'hDDDD_0000_0000_0002);
        set_sel(1'b0, 64'h008);
    endtask

    task automatic t_same_cycle();
        acc_odd    = 1'b0;
        sel_we     = 1'b1;
        sel_wdata  = 64'h018;
        data_we    = 1'b1;
        data_wdata = 64'hEEEE_0000_0000_0001;
        tick();
        chk("R10 new sel stored", sel_rdata, 64'h018);
        chk("R10 new entry untouched", data_rdata, 64'hBBBB_0000_0000_0003);
        set_sel(1'b0, 64'h008);
        chk("R10 old entry written", data_rdata, 64'hEEEE_0000_0000_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sel_write();
        t_scratch();
        t_status();
        t_other();
        t_pair();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule